// File: doc/BRIEF.md
# Sleep Control Register Decoder

This block holds a 16-bit power-management control register and turns software sleep commands into hardware requests. Software writes the register through a byte-enabled write port. A write that carries the sleep-enable bit does not store that bit. Instead, the block decodes a 3-bit sleep-type field from the same written value and raises one of three request pulses in that cycle: soft power-off, suspend-to-RAM, or suspend-to-disk. The suspend-to-disk request always comes with a shutdown request. The suspend-to-disk encoding is not fixed; it comes from a configuration strap.

The register's bit 0 is the interrupt-routing enable (SCI enable). A platform agent can set or clear it with dedicated command inputs. When the block is strapped for ACPI-only operation, reset leaves that bit set and the commands are ignored. The block also presents a 6-byte supported-states descriptor to boot firmware. The descriptor is built from the straps. Power sequencing itself is handled elsewhere.

Top module: `sleep_ctl_reg`

## Requirements
- R1: A write updates only the byte lanes whose enable is high (`wr_be[0]` selects bits 7:0, `wr_be[1]` selects bits 15:8). Bit 13 (sleep enable) always reads back as 0.
- R2: A sleep decode happens only in a cycle with `wr_en` high, `wr_be[1]` high and `wr_data[13]` high. The request outputs are driven combinationally in that same cycle and are low in every other cycle.
- R3: A decode with sleep type `wr_data[12:10]` equal to 0 raises `req_poweroff` alone.
- R4: A decode with sleep type 1 raises `req_suspend` alone.
- R5: A decode with sleep type 2 to 7 equal to `cfg_s4_code` raises `req_hibernate` and `req_poweroff` together. Any other type raises nothing.
- R6: After synchronous reset, `ctrl_q` is 0x0000, or 0x0001 when `cfg_acpi_only` is high.
- R7: With `cfg_acpi_only` low, `sci_set` sets bit 0 on the next edge. `sci_clr` clears bit 0 only when `sci_set` is low. Both commands take effect after a write in the same cycle.
- R8: With `cfg_acpi_only` high, `sci_set` and `sci_clr` have no effect on `ctrl_q`.
- R9: The `states_desc` byte k sits at bits 8k+7:8k. Bytes 0 and 5 are 0x80, and bytes 1 and 2 are 0x00. Byte 3 is 0x01 with bit 7 equal to `!cfg_s3_off`. Byte 4 is `cfg_s4_code` with bit 7 equal to `!cfg_s4_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte-lane enables for the write |
| wr_data | input | 16 | Write data, little-endian lanes |
| sci_set | input | 1 | Command to set the SCI-enable bit |
| sci_clr | input | 1 | Command to clear the SCI-enable bit |
| cfg_s4_code | input | 3 | Sleep-type value that means suspend-to-disk |
| cfg_s3_off | input | 1 | Suspend-to-RAM is not supported |
| cfg_s4_off | input | 1 | Suspend-to-disk is not supported |
| cfg_acpi_only | input | 1 | SCI enable forced on at reset, commands ignored |
| ctrl_q | output | 16 | Register readback |
| req_poweroff | output | 1 | Shutdown request pulse |
| req_suspend | output | 1 | Suspend-to-RAM request pulse |
| req_hibernate | output | 1 | Suspend-to-disk notification pulse |
| states_desc | output | 48 | Supported-states descriptor, byte 0 in bits 7:0 |

## Verification
The bench runs through five strap sets. These include a disk code of 0, which the power-off decode must shadow, and codes between 2 and 7 with the ACPI-only flag on and off. Random writes with biased sleep fields and random lane enables cover all eight sleep types. This shows whether each type reaches the right request and whether a write on the low lane only is kept from decoding. Simultaneous set and clear commands, with and without a write in the same cycle, check the command priority. The same commands under the ACPI-only flag check that they are ignored.

// File: rtl/slpc_pkg.sv
// Shared constants and types for the sleep control register.
// Assumes a 16-bit register split into byte lanes.
package slpc_pkg;
    localparam int REG_W       = 16;
    localparam int LANE_W      = 8;
    localparam int LANES       = REG_W / LANE_W;
    localparam int SCI_BIT     = 0;
    localparam int SLP_EN_BIT  = 13;
    localparam int TYP_LSB     = 10;
    localparam int TYP_W       = 3;
    localparam int DESC_BYTES  = 6;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_OFF     = 2'd1,
        ACT_SUSPEND = 2'd2,
        ACT_DISK    = 2'd3
    } slp_act_e;
endpackage

// File: rtl/slpc_store.sv
// Register storage with byte-lane writes and SCI-enable command handling.
// Assumes commands apply after the same-cycle write; sleep enable never stored.
module slpc_store
    import slpc_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int LW     = LANE_W,
    parameter int EN_BIT = SLP_EN_BIT,
    parameter int SCI    = SCI_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W/LW-1:0]   wr_be,
    input  logic [W-1:0]      wr_data,
    input  logic              sci_set,
    input  logic              sci_clr,
    input  logic              acpi_only,
    output logic [W-1:0]      q
);
    localparam int NL = W / LW;

    logic [W-1:0] lane_mask;
    logic [W-1:0] merged;
    logic [W-1:0] nxt;

    // Expand each lane enable into a bit mask.
    for (genvar l = 0; l < NL; l++) begin : g_lane
        assign lane_mask[l*LW +: LW] = {LW{wr_en & wr_be[l]}};
    end

    // Merge write data, drop sleep enable, then apply SCI commands.
    always_comb begin
        merged         = (q & ~lane_mask) | (wr_data & lane_mask);
        merged[EN_BIT] = 1'b0;
        nxt            = merged;
        if (!acpi_only) begin
            if (sci_set) begin
                nxt[SCI] = 1'b1;
            end else if (sci_clr) begin
                nxt[SCI] = 1'b0;
            end
        end
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q[SCI] <= acpi_only;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/slpc_decode.sv
// Sleep-type decode on a write carrying sleep enable.
// Assumes sleep enable and the type field share one byte lane.
module slpc_decode
    import slpc_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int LW     = LANE_W,
    parameter int EN_BIT = SLP_EN_BIT,
    parameter int T_LSB  = TYP_LSB,
    parameter int T_W    = TYP_W
) (
    input  logic              wr_en,
    input  logic [W/LW-1:0]   wr_be,
    input  logic [W-1:0]      wr_data,
    input  logic [T_W-1:0]    disk_code,
    output logic              req_off,
    output logic              req_sus,
    output logic              req_disk
);
    localparam int EN_LANE = EN_BIT / LW;

    logic           fire;
    logic [T_W-1:0] typ;
    slp_act_e       act;

    assign fire = wr_en & wr_be[EN_LANE] & wr_data[EN_BIT];
    assign typ  = wr_data[T_LSB +: T_W];

    // Pick the action; fixed codes take priority over the disk code.
    always_comb begin
        act = ACT_NONE;
        if (fire) begin
            if (typ == T_W'(0)) begin
                act = ACT_OFF;
            end else if (typ == T_W'(1)) begin
                act = ACT_SUSPEND;
            end else if (typ == disk_code) begin
                act = ACT_DISK;
            end
        end
    end

    // Map the action to request pulses.
    always_comb begin
        req_off  = (act == ACT_OFF) || (act == ACT_DISK);
        req_sus  = (act == ACT_SUSPEND);
        req_disk = (act == ACT_DISK);
    end
endmodule

// File: rtl/slpc_states.sv
// Supported-states descriptor builder from configuration straps.
// Assumes byte k occupies bits 8k+7:8k.
module slpc_states
    import slpc_pkg::*;
#(
    parameter int NB  = DESC_BYTES,
    parameter int T_W = TYP_W
) (
    input  logic [T_W-1:0]  disk_code,
    input  logic            s3_off,
    input  logic            s4_off,
    output logic [NB*8-1:0] desc
);
    // Build each descriptor byte.
    for (genvar k = 0; k < NB; k++) begin : g_byte
        if (k == 3) begin : g_s3
            assign desc[k*8 +: 8] = {~s3_off, 7'h01};
        end else if (k == 4) begin : g_s4
            assign desc[k*8 +: 8] = {~s4_off, (7 - T_W)'(0), disk_code};
        end else if (k == 0 || k == 5) begin : g_fixed
            assign desc[k*8 +: 8] = 8'h80;
        end else begin : g_zero
            assign desc[k*8 +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/sleep_ctl_reg.sv
// Top of the sleep control register: storage, sleep decode and descriptor.
// Assumes straps are stable while in use; requests are same-cycle pulses.
module sleep_ctl_reg
    import slpc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [LANES-1:0]       wr_be,
    input  logic [REG_W-1:0]       wr_data,
    input  logic                   sci_set,
    input  logic                   sci_clr,
    input  logic [TYP_W-1:0]       cfg_s4_code,
    input  logic                   cfg_s3_off,
    input  logic                   cfg_s4_off,
    input  logic                   cfg_acpi_only,
    output logic [REG_W-1:0]       ctrl_q,
    output logic                   req_poweroff,
    output logic                   req_suspend,
    output logic                   req_hibernate,
    output logic [DESC_BYTES*8-1:0] states_desc
);
    slpc_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .sci_set   (sci_set),
        .sci_clr   (sci_clr),
        .acpi_only (cfg_acpi_only),
        .q         (ctrl_q)
    );

    slpc_decode u_decode (
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .disk_code (cfg_s4_code),
        .req_off   (req_poweroff),
        .req_sus   (req_suspend),
        .req_disk  (req_hibernate)
    );

    slpc_states u_states (
        .disk_code (cfg_s4_code),
        .s3_off    (cfg_s3_off),
        .s4_off    (cfg_s4_off),
        .desc      (states_desc)
    );
endmodule

// File: rtl/sleep_ctl_chk.sv
// Property checker for the sleep control register, bound to the top.
module sleep_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic        sci_set,
    input logic        sci_clr,
    input logic [2:0]  cfg_s4_code,
    input logic        cfg_acpi_only,
    input logic [15:0] ctrl_q,
    input logic        req_poweroff,
    input logic        req_suspend,
    input logic        req_hibernate
);
    // R1
    slp_en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[13] == 1'b0);

    // R2
    req_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_poweroff || req_suspend || req_hibernate) |-> (wr_en && wr_be[1] && wr_data[13]));

    // R4
    suspend_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_suspend |-> (!req_poweroff && !req_hibernate && wr_data[12:10] == 3'd1));

    // R5
    disk_with_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_hibernate |-> (req_poweroff && wr_data[12:10] == cfg_s4_code && wr_data[12:10] > 3'd1));

    // R8
    acpi_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_acpi_only && !wr_en) |=> $stable(ctrl_q));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sci_set && !sci_clr) |=> $stable(ctrl_q));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_acpi_only && sci_set) |=> ctrl_q[0]);
endmodule

bind sleep_ctl_reg sleep_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_be         (wr_be),
    .wr_data       (wr_data),
    .sci_set       (sci_set),
    .sci_clr       (sci_clr),
    .cfg_s4_code   (cfg_s4_code),
    .cfg_acpi_only (cfg_acpi_only),
    .ctrl_q        (ctrl_q),
    .req_poweroff  (req_poweroff),
    .req_suspend   (req_suspend),
    .req_hibernate (req_hibernate)
);

// File: tb/tb_sleep_ctl_reg.sv
`timescale 1ns/1ps
module tb_sleep_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic        sci_set = 1'b0;
    logic        sci_clr = 1'b0;
    logic [2:0]  cfg_s4_code = 3'd0;
    logic        cfg_s3_off = 1'b0;
    logic        cfg_s4_off = 1'b0;
    logic        cfg_acpi_only = 1'b0;
    logic [15:0] ctrl_q;
    logic        req_poweroff, req_suspend, req_hibernate;
    logic [47:0] states_desc;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] model;

    always #5 clk = ~clk;

    sleep_ctl_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .sci_set(sci_set), .sci_clr(sci_clr), .cfg_s4_code(cfg_s4_code),
        .cfg_s3_off(cfg_s3_off), .cfg_s4_off(cfg_s4_off), .cfg_acpi_only(cfg_acpi_only),
        .ctrl_q(ctrl_q), .req_poweroff(req_poweroff), .req_suspend(req_suspend),
        .req_hibernate(req_hibernate), .states_desc(states_desc)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {hibernate, suspend, poweroff} (R2..R5).
    function automatic logic [2:0] exp_req(input logic en, input logic [1:0] be,
                                           input logic [15:0] d, input logic [2:0] code);
        logic [2:0] t;
        t = d[12:10];
        if (!(en && be[1] && d[13])) return 3'b000;
        if (t == 3'd0) return 3'b001;
        if (t == 3'd1) return 3'b010;
        if (t == code) return 3'b101;
        return 3'b000;
    endfunction

    // Expected register after one edge (R1, R7, R8).
    function automatic logic [15:0] exp_next(input logic [15:0] cur, input logic en,
                                             input logic [1:0] be, input logic [15:0] d,
                                             input logic s, input logic c, input logic ao);
        logic [15:0] n;
        n = cur;
        if (en && be[0]) n[7:0] = d[7:0];
        if (en && be[1]) n[15:8] = d[15:8];
        n[13] = 1'b0;
        if (!ao) begin
            if (s) n[0] = 1'b1;
            else if (c) n[0] = 1'b0;
        end
        return n;
    endfunction

    // Expected descriptor (R9).
    function automatic logic [47:0] exp_desc(input logic [2:0] code, input logic s3o, input logic s4o);
        return {8'h80, {~s4o, 4'h0, code}, {~s3o, 7'h01}, 8'h00, 8'h00, 8'h80};
    endfunction

    // One cycle: called at a falling edge, returns at the next one.
    task automatic cycle(input logic en, input logic [1:0] be, input logic [15:0] d,
                         input logic s, input logic c);
        logic [2:0] er;
        string tag;
        chk(cfg_acpi_only ? "R8 readback" : "R1/R7 readback", {32'h0, ctrl_q}, {32'h0, model});
        wr_en = en; wr_be = be; wr_data = d; sci_set = s; sci_clr = c;
        #1;
        er = exp_req(en, be, d, cfg_s4_code);
        if (!(en && be[1] && d[13])) tag = "R2 request";
        else if (d[12:10] == 3'd0) tag = "R3 request";
        else if (d[12:10] == 3'd1) tag = "R4 request";
        else tag = "R5 request";
        chk(tag, {45'h0, req_hibernate, req_suspend, req_poweroff}, {45'h0, er});
        model = exp_next(model, en, be, d, s, c, cfg_acpi_only);
        @(negedge clk);
        wr_en = 1'b0; sci_set = 1'b0; sci_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0; sci_set = 1'b0; sci_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model = cfg_acpi_only ? 16'h0001 : 16'h0000;
        #1;
        chk("R6 reset value", {32'h0, ctrl_q}, {32'h0, model});
    endtask

    initial begin
        logic [2:0]  codes [5];
        logic        aos [5];
        logic        s3s [5];
        logic        s4s [5];
        codes = '{3'd0, 3'd5, 3'd2, 3'd0, 3'd7};
        aos   = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
        s3s   = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
        s4s   = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
        void'($urandom(32'h1357_2468));
        model = 16'h0;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            cfg_s4_code = codes[k]; cfg_acpi_only = aos[k];
            cfg_s3_off = s3s[k]; cfg_s4_off = s4s[k];
            do_reset();
            chk("R9 descriptor", states_desc, exp_desc(cfg_s4_code, cfg_s3_off, cfg_s4_off));
            if (k == 0)
                chk("R9 default descriptor", states_desc, 48'h8080_8100_0080);
            // Directed corners.
            cycle(1'b1, 2'b11, 16'hFFFF, 1'b0, 1'b0);          // R1 sleep bit dropped, type 7
            cycle(1'b0, 2'b00, 16'h0000, 1'b1, 1'b1);          // R7/R8 set beats clear
            cycle(1'b0, 2'b00, 16'h0000, 1'b0, 1'b1);          // R7/R8 clear alone
            cycle(1'b1, 2'b11, 16'h0000, 1'b1, 1'b0);          // R7 set after write
            cycle(1'b1, 2'b01, 16'h2000, 1'b0, 1'b0);          // R2 low lane only
            cycle(1'b1, 2'b10, {2'b00, 1'b1, cfg_s4_code, 10'h0}, 1'b0, 1'b0); // R5 disk code
            cycle(1'b1, 2'b10, 16'h2000, 1'b0, 1'b0);          // R3 type 0
            cycle(1'b1, 2'b10, 16'h2400, 1'b0, 1'b1);          // R4 type 1
            cycle(1'b0, 2'b11, 16'h2400, 1'b0, 1'b0);          // R2 no strobe
            // Random traffic.
            for (int i = 0; i < 200; i++) begin
                logic [15:0] d;
                d = 16'($urandom);
                if ($urandom_range(0, 1) == 0) d[13] = 1'b1;
                cycle($urandom_range(0, 3) != 0, 2'($urandom), d,
                      $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0);
            end
            cycle(1'b0, 2'b00, 16'h0, 1'b0, 1'b0);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule